// File: doc/BRIEF.md
# Multi-Mode Pulse Position Counter

This block keeps a 32-bit position count from three asynchronous pulse lines, A, B and Z. Each line passes through a two-flop synchronizer. Edges are then detected on the system clock. A two-bit mode input selects how A and B are read:

- 4x quadrature decoding
- separate increment and decrement lines
- a count line with a direction line
- increment only

A range input selects the counting range:

- **Linear:** a signed range that saturates at its ends and sets sticky flags.
- **Ring:** wraps between zero and a programmable ring ceiling.

A rising edge on Z clears the count while the Z-clear enable is set. A synchronous software clear resets the count and both flags. A programmable target value is compared with the next count, so a one-cycle hit pulse appears together with the count that reaches the target.

Typical use is a motor or encoder position front end. The integrator sets the mode, range, ceiling and target as quasi-static configuration. The count and hit pulse are read by downstream logic.

Top module: `qpc_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `ovf`, `unf`, `hit` are 0. Asserting reset takes effect without a clock. Release passes through a two-stage synchronizer.
- R2: A level change on a pulse line sampled at clock edge k first shows in `count` after edge k+2, the third rising edge.
- R3: With `mode` = 0 (quadrature, 4x), every edge of A or of B is one step:
  - An A edge counts up when A differs from B after the edge, and down otherwise.
  - A B edge counts up when A equals B after the edge, and down otherwise.
  - A and B changing in the same sample gives no step.
- R4: With `mode` = 1, a rising edge on A adds one and a rising edge on B subtracts one. Both in the same sample cancel.
- R5: With `mode` = 2, a rising edge on A is one step. The step is up while B is low and down while B is high.
- R6: With `mode` = 3, a rising edge on A adds one. B has no effect.
- R7: With `ring_en` = 0, an up step at 0x7FFFFFFF holds the count and sets `ovf`. `ovf` stays set until a software clear.
- R8: With `ring_en` = 0, a down step at 0x80000000 holds the count and sets `unf`. `unf` stays set until a software clear.
- R9: With `ring_en` = 1, an up step at or above `ring_max` goes to 0, and a down step at 0 goes to `ring_max`. Every other step is ±1.
- R10: A rising edge on Z clears the count only while `z_clr_en` = 1. With `z_clr_en` = 0 the count is unchanged.
- R11: `sw_clr` high at a clock edge sets `count` to 0 and clears `ovf` and `unf`. It has priority over Z and over steps.
- R12: `hit` is high for exactly one cycle, in the cycle where `count` has just changed to a value equal to `target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a | input | 1 | Pulse line A, asynchronous |
| line_b | input | 1 | Pulse line B, asynchronous |
| line_z | input | 1 | Pulse line Z, asynchronous |
| mode | input | 2 | 0 quadrature, 1 up/down, 2 pulse+direction, 3 increment |
| ring_en | input | 1 | 1 selects ring range, 0 selects signed linear range |
| z_clr_en | input | 1 | Enables clearing of the count by a Z rising edge |
| sw_clr | input | 1 | Synchronous clear of count and flags |
| ring_max | input | 32 | Ring ceiling, 1 to 0xFFFFFFFF |
| target | input | 32 | Compare value for the hit pulse |
| count | output | 32 | Present count |
| ovf | output | 1 | Sticky linear overflow flag |
| unf | output | 1 | Sticky linear underflow flag |
| hit | output | 1 | One-cycle target-reached pulse |

## Verification
The step-size properties assume that `ring_en`, `ring_max` and `mode` hold steady across each clock edge. They also assume that `target` does not change in the cycle before a hit is examined. The hit property compares the count against the target value of the previous cycle.

The stimulus changes configuration only on falling edges and only while the pulse lines are idle. Each pulse is held for several cycles, so every sampled edge is a single clean transition.

Saturation corners cannot be reached by pulsing alone. The stimulus therefore reaches them through the ring range: it wraps down to a ceiling of 0x7FFFFFFF or 0x80000000, then switches to linear.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned CNT_W = 32;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_UPDN = 2'd1,
    MODE_PDIR = 2'd2,
    MODE_INC  = 2'd3
  } pmode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/qpc_rst_sync.sv
module qpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/qpc_line_sync.sv
module qpc_line_sync #(
  parameter int unsigned NLINES = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [NLINES-1:0] din,
  output logic [NLINES-1:0] lvl,
  output logic [NLINES-1:0] prv
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) pipe_q <= '0;
      else         pipe_q <= pipe_d;
    end

    assign lvl[i] = pipe_q[STAGES-1];
    assign prv[i] = pipe_q[STAGES];
  end
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
(
  input  pmode_e mode,
  input  logic   a_lvl,
  input  logic   a_prv,
  input  logic   b_lvl,
  input  logic   b_prv,
  output step_t  step
);
  logic a_chg, b_chg, a_rise, b_rise;

  always_comb begin
    a_chg  = a_lvl ^ a_prv;
    b_chg  = b_lvl ^ b_prv;
    a_rise = a_lvl & ~a_prv;
    b_rise = b_lvl & ~b_prv;
    step   = '0;
    unique case (mode)
      MODE_QUAD: begin
        if (a_chg ^ b_chg) begin
          if (a_chg) begin
            step.up = (a_lvl != b_lvl);
            step.dn = (a_lvl == b_lvl);
          end else begin
            step.up = (a_lvl == b_lvl);
            step.dn = (a_lvl != b_lvl);
          end
        end
      end
      MODE_UPDN: begin
        step.up = a_rise & ~b_rise;
        step.dn = b_rise & ~a_rise;
      end
      MODE_PDIR: begin
        step.up = a_rise & ~b_lvl;
        step.dn = a_rise &  b_lvl;
      end
      default: begin
        step.up = a_rise;
      end
    endcase
  end
endmodule

// File: rtl/qpc_count_core.sv
module qpc_count_core
  import qpc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  step_t         step,
  input  logic          z_rise,
  input  logic          z_clr_en,
  input  logic          sw_clr,
  input  logic          ring_en,
  input  logic [CW-1:0] ring_max,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf,
  output logic          hit
);
  localparam logic [CW-1:0] LIN_MAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] LIN_MIN = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] ONE     = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, hit_q, hit_d;
  logic          cnt_en, flg_en;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (sw_clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else if (z_rise && z_clr_en) begin
      cnt_d = '0;
    end else if (step.up) begin
      if (ring_en)               cnt_d = (cnt_q >= ring_max) ? '0 : cnt_q + ONE;
      else if (cnt_q == LIN_MAX) ovf_d = 1'b1;
      else                       cnt_d = cnt_q + ONE;
    end else if (step.dn) begin
      if (ring_en)               cnt_d = (cnt_q == '0) ? ring_max : cnt_q - ONE;
      else if (cnt_q == LIN_MIN) unf_d = 1'b1;
      else                       cnt_d = cnt_q - ONE;
    end
    cnt_en = (cnt_d != cnt_q);
    flg_en = (ovf_d != ovf_q) || (unf_d != unf_q);
    hit_d  = cnt_en && (cnt_d == target);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (flg_en) begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) hit_q <= 1'b0;
    else         hit_q <= hit_d;
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign unf   = unf_q;
  assign hit   = hit_q;
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int unsigned CW       = CNT_W,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_a,
  input  logic          line_b,
  input  logic          line_z,
  input  logic [1:0]    mode,
  input  logic          ring_en,
  input  logic          z_clr_en,
  input  logic          sw_clr,
  input  logic [CW-1:0] ring_max,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf,
  output logic          hit
);
  localparam int unsigned NLINES = 3;
  localparam int unsigned IA = 0;
  localparam int unsigned IB = 1;
  localparam int unsigned IZ = 2;

  logic              rst_sn;
  logic [NLINES-1:0] lvl, prv;
  logic              z_rise;
  step_t             step;

  qpc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  qpc_line_sync #(.NLINES(NLINES), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_sn (rst_sn),
    .din    ({line_z, line_b, line_a}),
    .lvl    (lvl),
    .prv    (prv)
  );

  assign z_rise = lvl[IZ] & ~prv[IZ];

  qpc_decoder u_dec (
    .mode  (pmode_e'(mode)),
    .a_lvl (lvl[IA]),
    .a_prv (prv[IA]),
    .b_lvl (lvl[IB]),
    .b_prv (prv[IB]),
    .step  (step)
  );

  qpc_count_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .step     (step),
    .z_rise   (z_rise),
    .z_clr_en (z_clr_en),
    .sw_clr   (sw_clr),
    .ring_en  (ring_en),
    .ring_max (ring_max),
    .target   (target),
    .count    (count),
    .ovf      (ovf),
    .unf      (unf),
    .hit      (hit)
  );
endmodule

// File: rtl/qpc_counter_chk.sv
module qpc_counter_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_clr,
  input logic          ring_en,
  input logic [CW-1:0] ring_max,
  input logic [CW-1:0] target,
  input logic [CW-1:0] count,
  input logic          ovf,
  input logic          unf,
  input logic          hit
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  AST_RESET_VALUES: assert property (@(posedge clk) !rst_n |-> (count == '0 && !ovf && !unf && !hit)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !sw_clr) |=> ovf); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (unf && !sw_clr) |=> unf); // R8
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!ring_en && !sw_clr) |=> (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE || count == '0)); // R7
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ring_en && !sw_clr) |=> (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE || count == '0 || count == $past(ring_max))); // R9
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) sw_clr |=> (count == '0 && !ovf && !unf)); // R11
  AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) hit |-> count == $past(target)); // R12
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) hit |=> !hit); // R12
endmodule

bind qpc_counter qpc_counter_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_clr   (sw_clr),
  .ring_en  (ring_en),
  .ring_max (ring_max),
  .target   (target),
  .count    (count),
  .ovf      (ovf),
  .unf      (unf),
  .hit      (hit)
);

// File: tb/qpc_counter_bench.sv
`timescale 1ns/1ps
module qpc_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_a = 1'b0, line_b = 1'b0, line_z = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        ring_en = 1'b0, z_clr_en = 1'b0, sw_clr = 1'b0;
  logic [31:0] ring_max = 32'd100, target = 32'h7FFF0000;
  logic [31:0] count;
  logic        ovf, unf, hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qpc_counter u_qpc_counter (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b), .line_z(line_z),
    .mode(mode), .ring_en(ring_en), .z_clr_en(z_clr_en), .sw_clr(sw_clr),
    .ring_max(ring_max), .target(target), .count(count), .ovf(ovf), .unf(unf), .hit(hit)
  );

  // vector: {mode[1:0], a, b, expected count[31:0]}
  localparam int NV = 24;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 32'd1},   // R3 up
    {2'd0, 1'b1, 1'b1, 32'd2},   // R3
    {2'd0, 1'b0, 1'b1, 32'd3},   // R3
    {2'd0, 1'b0, 1'b0, 32'd4},   // R3
    {2'd0, 1'b0, 1'b1, 32'd3},   // R3 down
    {2'd0, 1'b1, 1'b1, 32'd2},   // R3
    {2'd0, 1'b1, 1'b0, 32'd1},   // R3
    {2'd0, 1'b0, 1'b0, 32'd0},   // R3
    {2'd1, 1'b1, 1'b0, 32'd1},   // R4 inc
    {2'd1, 1'b0, 1'b0, 32'd1},   // R4
    {2'd1, 1'b0, 1'b1, 32'd0},   // R4 dec
    {2'd1, 1'b0, 1'b0, 32'd0},   // R4
    {2'd1, 1'b1, 1'b1, 32'd0},   // R4 cancel
    {2'd1, 1'b0, 1'b0, 32'd0},   // R4
    {2'd2, 1'b1, 1'b0, 32'd1},   // R5 up
    {2'd2, 1'b0, 1'b0, 32'd1},   // R5
    {2'd2, 1'b1, 1'b0, 32'd2},   // R5
    {2'd2, 1'b0, 1'b1, 32'd2},   // R5
    {2'd2, 1'b1, 1'b1, 32'd1},   // R5 down
    {2'd2, 1'b0, 1'b0, 32'd1},   // R5
    {2'd3, 1'b1, 1'b0, 32'd2},   // R6
    {2'd3, 1'b0, 1'b1, 32'd2},   // R6 B ignored
    {2'd3, 1'b1, 1'b0, 32'd3},   // R6
    {2'd3, 1'b0, 1'b0, 32'd3}    // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_a();
    line_a = 1'b1; settle();
    line_a = 1'b0; settle();
  endtask

  task automatic pulse_b();
    line_b = 1'b1; settle();
    line_b = 1'b0; settle();
  endtask

  task automatic pulse_z();
    line_z = 1'b1; settle();
    line_z = 1'b0; settle();
  endtask

  task automatic soft_clear();
    sw_clr = 1'b1; @(negedge clk);
    sw_clr = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 32'd0);
    chk("R1 flags in reset", {29'd0, ovf, unf, hit}, 32'd0);
    rst_n = 1'b1;
    settle();
    chk("R1 count after release", count, 32'd0);

    for (int i = 0; i < NV; i++) begin
      mode   = VEC[i][35:34];
      line_a = VEC[i][33];
      line_b = VEC[i][32];
      settle();
      chk($sformatf("R3-6 vector %0d mode %0d", i, VEC[i][35:34]), count, VEC[i][31:0]);
    end

    soft_clear();
    chk("R11 clear count", count, 32'd0);

    // R2 latency, increment mode
    mode = 2'd3;
    line_a = 1'b1;
    @(posedge clk); #1 chk("R2 edge1", count, 32'd0);
    @(posedge clk); #1 chk("R2 edge2", count, 32'd0);
    @(posedge clk); #1 chk("R2 edge3", count, 32'd1);
    @(negedge clk); line_a = 1'b0; settle();

    // R12 hit pulse
    target = 32'd2;
    line_a = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R12 hit high", {31'd0, hit}, 32'd1);
    chk("R12 count at hit", count, 32'd2);
    @(posedge clk); #1 chk("R12 hit one cycle", {31'd0, hit}, 32'd0);
    @(negedge clk); line_a = 1'b0; settle();

    // R10 Z clear enable
    z_clr_en = 1'b0; pulse_z();
    chk("R10 Z disabled", count, 32'd2);
    z_clr_en = 1'b1; pulse_z();
    chk("R10 Z enabled", count, 32'd0);
    z_clr_en = 1'b0;

    // R9 ring wrap
    ring_en = 1'b1; ring_max = 32'd3;
    pulse_a(); pulse_a(); pulse_a();
    chk("R9 at ceiling", count, 32'd3);
    pulse_a();
    chk("R9 wrap up", count, 32'd0);
    mode = 2'd1; pulse_b();
    chk("R9 wrap down", count, 32'd3);
    soft_clear();

    // R7 overflow
    ring_max = 32'h7FFFFFFF; pulse_b();
    chk("R7 preload", count, 32'h7FFFFFFF);
    ring_en = 1'b0; pulse_a();
    chk("R7 hold", count, 32'h7FFFFFFF);
    chk("R7 ovf set", {31'd0, ovf}, 32'd1);
    pulse_b(); pulse_a();
    chk("R7 ovf sticky", {31'd0, ovf}, 32'd1);
    chk("R8 unf clear", {31'd0, unf}, 32'd0);
    soft_clear();
    chk("R11 ovf cleared", {30'd0, ovf, unf}, 32'd0);

    // R8 underflow
    ring_en = 1'b1; ring_max = 32'h80000000; pulse_b();
    chk("R8 preload", count, 32'h80000000);
    ring_en = 1'b0; pulse_b();
    chk("R8 hold", count, 32'h80000000);
    chk("R8 unf set", {31'd0, unf}, 32'd1);
    soft_clear();
    chk("R11 unf cleared", {31'd0, unf}, 32'd0);

    // R1 asynchronous reset
    pulse_a();
    chk("R1 pre-reset", count, 32'd1);
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", count, 32'd0);
    finish_run();
  end
endmodule